// File: doc/BRIEF.md
# Two-Wire Serial Controller Register Interface

This block is the processor-facing register file of a two-wire serial bus controller. It holds three registers behind a small synchronous read/write port: a control register (transfer-done flag, enable, interrupt enable and a sticky write-collision flag), a status register (a status code supplied by the bus engine plus a writable prescaler), and a data register that holds the byte to send and the last byte received.

On the engine side it takes a strobe that raises the transfer-done flag, the current status code, and a received-byte strobe. It returns the data byte to shift out, the prescaler, the enable level and a one-cycle abort pulse. The processor may change the data register only while the transfer-done flag is high. A data write made while the flag is low is dropped and raises the collision flag. The interrupt request follows the flag, gated by the local and global interrupt enables.

Top module: `twc_regif`

## Requirements
- R1: After reset, reading the control register gives 0x00, the status register 0xF8 (code 5'h1F) and the data register 0xFF, and `irq` and `eng_abort` are low.
- R2: A data write (address 2) while the flag is high loads `cpu_wdata` into the data register and clears the collision flag.
- R3: A data write while the flag is low leaves the data register unchanged and sets the collision flag (control bit 3), which stays set until a later data write made while the flag is high.
- R4: `eng_rx_vld` while the flag is low loads `eng_rx_byte` into the data register. While the flag is high the strobe is ignored and the data register stays stable.
- R5: `eng_flag_set` sets the flag (control bit 7). A control write (address 0) with bit 7 set clears it. If both happen in the same cycle, the set wins. Otherwise the flag holds.
- R6: After each clock edge, `irq` equals flag AND interrupt enable (control bit 0) AND the `glb_irq_en` value sampled at that edge. It therefore drops at the same edge as a clearing write.
- R7: Every control write with bit 2 equal to 0 produces a one-cycle `eng_abort` pulse after the edge, and `eng_en` follows control bit 2.
- R8: The status register reads {code, 0, prescaler}: bits 7..3 are the engine code registered one edge earlier, bit 2 is zero, and bits 1..0 are the prescaler. A status write (address 1) changes only the prescaler, which also drives `eng_presc`.
- R9: The control register reads bit 7 flag, bit 3 collision, bit 2 enable and bit 0 interrupt enable, with bits 6..4 and 1 always zero. Writes to bits 3, 1 and 6..4 have no effect.
- R10: `cpu_rdata` is registered: after an edge it shows the register selected by `cpu_addr` as it stood before that edge. Address 3 reads zero.
- R11: `eng_tx_byte` always equals the data register, so after a received byte it holds the last byte seen on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| eng_flag_set | input | 1 | Engine strobe that raises the transfer-done flag |
| eng_status | input | 5 | Engine status code |
| eng_rx_vld | input | 1 | Received-byte strobe |
| eng_rx_byte | input | 8 | Received byte |
| eng_tx_byte | output | 8 | Byte to shift out (data register) |
| eng_presc | output | 2 | Bit-rate prescaler |
| eng_en | output | 1 | Controller enable level |
| eng_abort | output | 1 | One-cycle abort pulse |

## Verification
A wrong flag or collision state shows up within one edge, either on `irq` or on the next control-register read. A data register corrupted by a dropped write or an ignored receive strobe appears on `eng_tx_byte` in the very cycle after the bad edge. The bench therefore compares every output after every edge against a cycle model driven by random writes, engine strobes and addresses. Directed sequences cover the simultaneous-strobe priorities and the reset values.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTL_FLAG = 7;
  localparam int CTL_COLL = 3;
  localparam int CTL_EN   = 2;
  localparam int CTL_IE   = 0;

  localparam logic [4:0] CODE_RST = 5'h1F;
endpackage

// File: rtl/twc_ctl_regs.sv
module twc_ctl_regs (
  input  logic clk,
  input  logic rst,
  input  logic wr_ctl,
  input  logic clr_bit,
  input  logic en_bit,
  input  logic ie_bit,
  input  logic flag_set,
  input  logic glb_ie,
  output logic flag,
  output logic en,
  output logic ie,
  output logic abort,
  output logic irq
);
  logic flag_d, en_d, ie_d;

  always_comb begin
    flag_d = flag;
    en_d   = en;
    ie_d   = ie;
    if (wr_ctl) begin
      en_d = en_bit;
      ie_d = ie_bit;
      if (clr_bit) flag_d = 1'b0;
    end
    if (flag_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      en    <= 1'b0;
      ie    <= 1'b0;
      abort <= 1'b0;
      irq   <= 1'b0;
    end else begin
      flag  <= flag_d;
      en    <= en_d;
      ie    <= ie_d;
      abort <= wr_ctl & ~en_bit;
      irq   <= flag_d & ie_d & glb_ie;
    end
  end
endmodule

// File: rtl/twc_data_reg.sv
module twc_data_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  input  logic              rx_vld,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] data,
  output logic              coll
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '1;
      coll <= 1'b0;
    end else begin
      if (rx_vld && !flag)
        data <= rx_byte;
      else if (wr_data && flag)
        data <= wdata;
      if (wr_data)
        coll <= ~flag;
    end
  end
endmodule

// File: rtl/twc_stat_reg.sv
module twc_stat_reg #(
  parameter int CODE_W = 5,
  parameter int PRE_W  = 2,
  parameter logic [CODE_W-1:0] CODE_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic [PRE_W-1:0]  pre_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code,
  output logic [PRE_W-1:0]  presc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= CODE_INIT;
      presc <= '0;
    end else begin
      code <= code_in;
      if (wr_stat) presc <= pre_in;
    end
  end
endmodule

// File: rtl/twc_regif.sv
module twc_regif #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 5,
  parameter int PRE_W  = 2,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              glb_irq_en,
  output logic              irq,
  input  logic              eng_flag_set,
  input  logic [CODE_W-1:0] eng_status,
  input  logic              eng_rx_vld,
  input  logic [DATA_W-1:0] eng_rx_byte,
  output logic [DATA_W-1:0] eng_tx_byte,
  output logic [PRE_W-1:0]  eng_presc,
  output logic              eng_en,
  output logic              eng_abort
);
  import twc_pkg::*;

  localparam int STAT_W = CODE_W + 1 + PRE_W;

  logic wr_ctl, wr_stat, wr_data;
  logic flag_q, ie_q, coll_q;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] rd_d;

  assign wr_ctl  = cpu_wr && (cpu_addr == ADDR_W'(ADDR_CTL));
  assign wr_stat = cpu_wr && (cpu_addr == ADDR_W'(ADDR_STAT));
  assign wr_data = cpu_wr && (cpu_addr == ADDR_W'(ADDR_DATA));

  twc_ctl_regs u_ctl (
    .clk      (clk),
    .rst      (rst),
    .wr_ctl   (wr_ctl),
    .clr_bit  (cpu_wdata[CTL_FLAG]),
    .en_bit   (cpu_wdata[CTL_EN]),
    .ie_bit   (cpu_wdata[CTL_IE]),
    .flag_set (eng_flag_set),
    .glb_ie   (glb_irq_en),
    .flag     (flag_q),
    .en       (eng_en),
    .ie       (ie_q),
    .abort    (eng_abort),
    .irq      (irq)
  );

  twc_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wr_data),
    .wdata   (cpu_wdata),
    .flag    (flag_q),
    .rx_vld  (eng_rx_vld),
    .rx_byte (eng_rx_byte),
    .data    (eng_tx_byte),
    .coll    (coll_q)
  );

  twc_stat_reg #(
    .CODE_W    (CODE_W),
    .PRE_W     (PRE_W),
    .CODE_INIT (CODE_W'(CODE_RST))
  ) u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_stat (wr_stat),
    .pre_in  (cpu_wdata[PRE_W-1:0]),
    .code_in (eng_status),
    .code    (code_q),
    .presc   (eng_presc)
  );

  always_comb begin
    rd_d = '0;
    case (cpu_addr)
      ADDR_W'(ADDR_CTL): begin
        rd_d[CTL_FLAG] = flag_q;
        rd_d[CTL_COLL] = coll_q;
        rd_d[CTL_EN]   = eng_en;
        rd_d[CTL_IE]   = ie_q;
      end
      ADDR_W'(ADDR_STAT): rd_d[STAT_W-1:0] = {code_q, 1'b0, eng_presc};
      ADDR_W'(ADDR_DATA): rd_d = eng_tx_byte;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_d;
  end
endmodule

// File: rtl/twc_regif_chk.sv
module twc_regif_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              eng_flag_set,
  input logic              eng_rx_vld,
  input logic              flag,
  input logic              coll,
  input logic              irq,
  input logic              eng_abort,
  input logic              eng_en,
  input logic [DATA_W-1:0] eng_tx_byte
);
  logic dwr, cwr;
  assign dwr = cpu_wr && (cpu_addr == ADDR_W'(2));
  assign cwr = cpu_wr && (cpu_addr == ADDR_W'(0));

  // R2
  legal_write_chk: assert property (@(posedge clk) disable iff (rst)
    (dwr && flag) |=> (eng_tx_byte == $past(cpu_wdata) && !coll));

  // R3
  collision_chk: assert property (@(posedge clk) disable iff (rst)
    (dwr && !flag && !eng_rx_vld) |=> (coll && $stable(eng_tx_byte)));

  // R4
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !dwr) |=> $stable(eng_tx_byte));

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(eng_flag_set));

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  // R7
  abort_src_chk: assert property (@(posedge clk) disable iff (rst)
    eng_abort |-> (!eng_en && $past(cwr && !cpu_wdata[2])));
endmodule

bind twc_regif twc_regif_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_wr       (cpu_wr),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .eng_flag_set (eng_flag_set),
  .eng_rx_vld   (eng_rx_vld),
  .flag         (flag_q),
  .coll         (coll_q),
  .irq          (irq),
  .eng_abort    (eng_abort),
  .eng_en       (eng_en),
  .eng_tx_byte  (eng_tx_byte)
);

// File: tb/test_twc_regif.sv
module test_twc_regif;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       glb_irq_en = 1'b1;
  logic       irq;
  logic       eng_flag_set = 1'b0;
  logic [4:0] eng_status = 5'h1F;
  logic       eng_rx_vld = 1'b0;
  logic [7:0] eng_rx_byte = 8'd0;
  logic [7:0] eng_tx_byte;
  logic [1:0] eng_presc;
  logic       eng_en;
  logic       eng_abort;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  bit         m_flag, m_en, m_ie, m_coll, m_abort, m_irq;
  logic [7:0] m_data;
  logic [1:0] m_pre;
  logic [4:0] m_stat;

  always #10 clk = ~clk;

  twc_regif i_twc_regif (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .glb_irq_en(glb_irq_en),
    .irq(irq), .eng_flag_set(eng_flag_set), .eng_status(eng_status),
    .eng_rx_vld(eng_rx_vld), .eng_rx_byte(eng_rx_byte),
    .eng_tx_byte(eng_tx_byte), .eng_presc(eng_presc), .eng_en(eng_en),
    .eng_abort(eng_abort)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {m_flag, 3'b000, m_coll, m_en, 1'b0, m_ie};
      2'd1: return {m_stat, 1'b0, m_pre};
      2'd2: return m_data;
      default: return 8'h00;
    endcase
  endfunction

  // one clock: drive, advance model, compare every output
  task automatic step(input bit wr, input logic [1:0] a, input logic [7:0] d,
                      input bit fset, input bit rxv, input logic [7:0] rxb);
    logic [7:0] exp_rd;
    @(negedge clk);
    cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    eng_flag_set = fset; eng_rx_vld = rxv; eng_rx_byte = rxb;
    exp_rd = model_read(a);
    if (rxv && !m_flag) m_data = rxb;
    else if (wr && a == 2'd2 && m_flag) m_data = d;
    if (wr && a == 2'd2) m_coll = !m_flag;
    m_abort = 1'b0;
    if (wr && a == 2'd0) begin
      m_en = d[2]; m_ie = d[0]; m_abort = !d[2];
      if (d[7]) m_flag = 1'b0;
    end
    if (fset) m_flag = 1'b1;
    if (wr && a == 2'd1) m_pre = d[1:0];
    m_stat = eng_status;
    m_irq = m_flag && m_ie && glb_irq_en;
    @(posedge clk);
    #1;
    case (a)
      2'd0: chk(cpu_rdata == exp_rd, "R9 ctl read", cpu_rdata, exp_rd);
      2'd1: chk(cpu_rdata == exp_rd, "R8 status read", cpu_rdata, exp_rd);
      default: chk(cpu_rdata == exp_rd, "R10 read", cpu_rdata, exp_rd);
    endcase
    chk(eng_tx_byte == m_data, "R11 tx byte", eng_tx_byte, m_data);
    chk(irq == m_irq, "R6 irq", {7'd0, irq}, {7'd0, m_irq});
    chk(eng_abort == m_abort, "R7 abort", {7'd0, eng_abort}, {7'd0, m_abort});
    chk(eng_en == m_en, "R7 enable", {7'd0, eng_en}, {7'd0, m_en});
    chk(eng_presc == m_pre, "R8 prescaler", {6'd0, eng_presc}, {6'd0, m_pre});
  endtask

  task automatic rd(input logic [1:0] a);
    step(1'b0, a, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    m_flag = 0; m_en = 0; m_ie = 0; m_coll = 0; m_abort = 0; m_irq = 0;
    m_data = 8'hFF; m_pre = 2'd0; m_stat = 5'h1F;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset values
    rd(2'd0); chk(cpu_rdata == 8'h00, "R1 ctl reset", cpu_rdata, 8'h00);
    chk(irq == 1'b0 && eng_abort == 1'b0, "R1 outputs reset", {6'd0, irq, eng_abort}, 8'h00);
    rd(2'd1); chk(cpu_rdata == 8'hF8, "R1 status reset", cpu_rdata, 8'hF8);
    rd(2'd2); chk(cpu_rdata == 8'hFF, "R1 data reset", cpu_rdata, 8'hFF);

    // R3 dropped write while flag low
    step(1'b1, 2'd2, 8'h5A, 1'b0, 1'b0, 8'h00);
    rd(2'd2); chk(cpu_rdata == 8'hFF, "R3 data kept", cpu_rdata, 8'hFF);
    rd(2'd0); chk(cpu_rdata == 8'h08, "R3 collision set", cpu_rdata, 8'h08);

    // R4 receive while flag low
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h3C);
    rd(2'd2); chk(cpu_rdata == 8'h3C, "R4 rx load", cpu_rdata, 8'h3C);

    // R5 flag set
    step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00);
    rd(2'd0); chk(cpu_rdata == 8'h88, "R5 flag set", cpu_rdata, 8'h88);

    // R4 receive ignored while flag high
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h99);
    rd(2'd2); chk(cpu_rdata == 8'h3C, "R4 rx ignored", cpu_rdata, 8'h3C);

    // R2 legal write clears collision
    step(1'b1, 2'd2, 8'hA5, 1'b0, 1'b0, 8'h00);
    rd(2'd2); chk(cpu_rdata == 8'hA5, "R2 data written", cpu_rdata, 8'hA5);
    rd(2'd0); chk(cpu_rdata == 8'h80, "R2 collision cleared", cpu_rdata, 8'h80);

    // R9 reserved bits ignored, R6 irq rises
    step(1'b1, 2'd0, 8'h7F, 1'b0, 1'b0, 8'h00);
    chk(irq == 1'b1, "R6 irq high", {7'd0, irq}, 8'h01);
    rd(2'd0); chk(cpu_rdata == 8'h85, "R9 reserved zero", cpu_rdata, 8'h85);

    // R5 clear and set in same cycle: set wins
    step(1'b1, 2'd0, 8'h85, 1'b1, 1'b0, 8'h00);
    rd(2'd0); chk(cpu_rdata == 8'h85, "R5 set wins", cpu_rdata, 8'h85);

    // R6 irq drops with clear
    step(1'b1, 2'd0, 8'h85, 1'b0, 1'b0, 8'h00);
    chk(irq == 1'b0, "R6 irq cleared", {7'd0, irq}, 8'h00);
    rd(2'd0); chk(cpu_rdata == 8'h05, "R5 flag cleared", cpu_rdata, 8'h05);

    // R7 abort pulse
    step(1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 8'h00);
    chk(eng_abort == 1'b1 && eng_en == 1'b0, "R7 abort pulse", {6'd0, eng_abort, eng_en}, 8'h02);
    rd(2'd1);
    chk(eng_abort == 1'b0, "R7 abort one cycle", {7'd0, eng_abort}, 8'h00);

    // R8 status: only prescaler writable
    step(1'b1, 2'd1, 8'hFF, 1'b0, 1'b0, 8'h00);
    rd(2'd1); chk(cpu_rdata == 8'hFB, "R8 status write", cpu_rdata, 8'hFB);
    eng_status = 5'h08;
    rd(2'd0);
    rd(2'd1); chk(cpu_rdata == 8'h43, "R8 status code", cpu_rdata, 8'h43);

    // R10 unused address
    rd(2'd3); chk(cpu_rdata == 8'h00, "R10 addr3 zero", cpu_rdata, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit wr, fs, rv;
      wr = ($urandom % 2) == 0;
      fs = ($urandom % 8) == 0;
      rv = ($urandom % 6) == 0;
      if (($urandom % 16) == 0) glb_irq_en = ~glb_irq_en;
      if (($urandom % 32) == 0) eng_status = 5'($urandom);
      step(wr, 2'($urandom), 8'($urandom), fs, rv, 8'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule